// File: doc/BRIEF.md
# Periodic Interrupt Request Controller

This block turns single-cycle ticks from an external periodic timer into a prioritised interrupt request for the processor. A 16-bit control register holds a 3-bit request priority and an 8-bit vector number. When a tick arrives and the priority field is nonzero, the block latches a pending request. While the request is pending, it drives the programmed priority on its request output.

When the processor runs an acknowledge cycle at the priority it sees, the block answers with its vector. It places the raw 8-bit vector on a data output for one cycle and drops the pending request. Scaling the vector into a table offset and adding a table base is done by logic outside this block. The timer itself keeps counting whether or not the request is enabled.

Only supervisor-mode accesses can reach the control register. A user-mode access reads as zero, changes nothing and raises a one-cycle error flag.

Top module: `periodic_irq_ctrl`

## Requirements
- R1: Register bits 15..11 always read as zero, and writing ones to them has no effect.
- R2: After reset the register reads 0x000F: priority field 0, vector 0x0F.
- R3: The priority field occupies bits 10..8 and the vector bits 7..0. A supervisor read (regSel=1, regWr=0, regSupv=1) returns the register on regRdata in the same cycle, and regRdata is zero when no supervisor read is under way. A supervisor write takes effect at the clock edge.
- R4: A tick while the priority field is nonzero sets the pending request. From the next cycle irqLevel shows the priority field while pending, and irqLevel is 0 whenever nothing is pending.
- R5: A tick while the priority field is 0 raises no request.
- R6: An acknowledge (ackValid=1) whose ackLevel equals the nonzero priority field while a request is pending has three effects on the next cycle. vecValid is 1 for one cycle, vecData carries the vector, and the pending request is cleared. vecData is 0 when vecValid is 0.
- R7: An acknowledge at a different level, or with nothing pending, changes nothing and produces no vector.
- R8: A user-mode access (regSel=1, regSupv=0) reads as zero and leaves the register unchanged. accessErr is 1 in the following cycle only.
- R9: A supervisor write of 0 to the priority field while a request is pending clears the request at that edge.
- R10: A tick in the same cycle as a matching acknowledge has two results. The acknowledge is served, and the request stays pending for the new tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 1 | Register access strobe |
| regWr | input | 1 | 1 = write, 0 = read |
| regSupv | input | 1 | 1 = supervisor-mode access |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data |
| accessErr | output | 1 | One-cycle flag after a user-mode access |
| tick | input | 1 | Periodic timer tick, one cycle wide |
| irqLevel | output | 3 | Encoded request priority, 0 = none |
| ackValid | input | 1 | Interrupt-acknowledge cycle present |
| ackLevel | input | 3 | Priority being acknowledged |
| vecValid | output | 1 | Vector strobe |
| vecData | output | 8 | Vector number |

## Verification
Assertions check three rules on every cycle: no request is pending while the priority is 0, a vector strobe always follows a matching acknowledge with the vector held in the register, and a user-mode write never changes the register. A further cycle check requires an access error to follow only a user-mode access. Three cases can only be shown by the bench's scenarios, which compare the design against a cycle-level reference model on every clock. These are the reserved-bit masking and reset value, the tick that coincides with an acknowledge, and disabling the priority while a request is pending.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic regWrite;
    logic regRead;
    logic vecLoad;
  } pirqStrobe_t;
endpackage

// File: rtl/pirq_datapath.sv
module pirq_datapath
  import pirq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LVL_W = 3,
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] RESET_VEC = 8'h0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  pirqStrobe_t       stb,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [LVL_W-1:0]  curLevel,
  output logic [VEC_W-1:0]  curVector,
  output logic              vecValid,
  output logic [VEC_W-1:0]  vecData
);
  localparam int LVL_LSB = VEC_W;
  localparam int RSV_LSB = VEC_W + LVL_W;

  logic [LVL_W-1:0]  ctlLevel;
  logic [VEC_W-1:0]  ctlVector;
  logic [DATA_W-1:0] packedReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlLevel  <= '0;
      ctlVector <= RESET_VEC;
    end else if (stb.regWrite) begin
      ctlLevel  <= regWdata[LVL_LSB +: LVL_W];
      ctlVector <= regWdata[VEC_W-1:0];
    end
  end

  generate
    if (DATA_W > RSV_LSB) begin : g_pad
      assign packedReg = {{(DATA_W-RSV_LSB){1'b0}}, ctlLevel, ctlVector};
    end else begin : g_nopad
      assign packedReg = {ctlLevel, ctlVector};
    end
  endgenerate

  assign regRdata  = stb.regRead ? packedReg : '0;
  assign curLevel  = ctlLevel;
  assign curVector = ctlVector;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecValid <= 1'b0;
      vecData  <= '0;
    end else begin
      vecValid <= stb.vecLoad;
      vecData  <= stb.vecLoad ? ctlVector : '0;
    end
  end

  // R6
  vec_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> vecData == $past(ctlVector));
  // R6
  vec_idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !vecValid |-> vecData == '0);
endmodule

// File: rtl/pirq_control.sv
module pirq_control
  import pirq_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic             regWr,
  input  logic             regSupv,
  input  logic [LVL_W-1:0] wrLevel,
  input  logic             tick,
  input  logic             ackValid,
  input  logic [LVL_W-1:0] ackLevel,
  input  logic [LVL_W-1:0] curLevel,
  output pirqStrobe_t      stb,
  output logic [LVL_W-1:0] irqLevel,
  output logic             accessErr
);
  logic pendQ;
  logic enabled;
  logic ackHit;
  logic supWrite;
  logic userAcc;

  assign enabled  = curLevel != '0;
  assign supWrite = regSel && regWr && regSupv;
  assign userAcc  = regSel && !regSupv;
  assign ackHit   = ackValid && enabled && pendQ && (ackLevel == curLevel);

  assign stb.regWrite = supWrite;
  assign stb.regRead  = regSel && !regWr && regSupv;
  assign stb.vecLoad  = ackHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ     <= 1'b0;
      accessErr <= 1'b0;
    end else begin
      accessErr <= userAcc;
      if (supWrite && wrLevel == '0) pendQ <= 1'b0;
      else if (tick && enabled)      pendQ <= 1'b1;
      else if (ackHit)               pendQ <= 1'b0;
    end
  end

  assign irqLevel = pendQ ? curLevel : '0;

  // R5
  disabled_no_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curLevel == '0) |-> !pendQ);
  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackHit && !tick) |=> !pendQ);
  // R8
  err_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |-> $past(regSel && !regSupv));
endmodule

// File: rtl/periodic_irq_ctrl.sv
module periodic_irq_ctrl
  import pirq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LVL_W = 3,
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] RESET_VEC = 8'h0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWr,
  input  logic              regSupv,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              accessErr,
  input  logic              tick,
  output logic [LVL_W-1:0]  irqLevel,
  input  logic              ackValid,
  input  logic [LVL_W-1:0]  ackLevel,
  output logic              vecValid,
  output logic [VEC_W-1:0]  vecData
);
  localparam int LVL_LSB = VEC_W;

  pirqStrobe_t      stb;
  logic [LVL_W-1:0] curLevel;
  logic [VEC_W-1:0] curVector;

  pirq_control #(.LVL_W(LVL_W)) u_ctl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regSupv(regSupv),
    .wrLevel(regWdata[LVL_LSB +: LVL_W]), .tick(tick), .ackValid(ackValid),
    .ackLevel(ackLevel), .curLevel(curLevel), .stb(stb), .irqLevel(irqLevel),
    .accessErr(accessErr)
  );

  pirq_datapath #(.DATA_W(DATA_W), .LVL_W(LVL_W), .VEC_W(VEC_W), .RESET_VEC(RESET_VEC)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regWdata(regWdata), .regRdata(regRdata),
    .curLevel(curLevel), .curVector(curVector), .vecValid(vecValid), .vecData(vecData)
  );

  // R8
  user_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regWr && !regSupv) |=> $stable({curLevel, curVector}));
  // R6
  ack_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(ackValid && ackLevel == irqLevel && irqLevel != '0));
endmodule

// File: tb/periodic_irq_ctrl_bench.sv
module periodic_irq_ctrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regSel = 0, regWr = 0, regSupv = 0, tick = 0, ackValid = 0;
  logic [15:0] regWdata = '0;
  logic [2:0]  ackLevel = '0;
  logic [15:0] regRdata;
  logic        accessErr, vecValid;
  logic [2:0]  irqLevel;
  logic [7:0]  vecData;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  int mReg, mPend, mVV, mVD, mErr;

  always #4 clk = ~clk;

  periodic_irq_ctrl u_periodic_irq_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regSupv(regSupv),
    .regWdata(regWdata), .regRdata(regRdata), .accessErr(accessErr), .tick(tick),
    .irqLevel(irqLevel), .ackValid(ackValid), .ackLevel(ackLevel),
    .vecValid(vecValid), .vecData(vecData)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expRd();
    return (regSel && !regWr && regSupv) ? mReg : 0;
  endfunction

  task automatic compareAll();
    chk("R4 irqLevel", int'(irqLevel), mPend ? ((mReg >> 8) & 7) : 0);
    chk("R6 vecValid", int'(vecValid), mVV);
    chk("R6 vecData", int'(vecData), mVD);
    chk("R8 accessErr", int'(accessErr), mErr);
    chk("R3 regRdata", int'(regRdata), expRd());
  endtask

  task automatic step();
    int lvl, hit, nPend;
    @(posedge clk);
    lvl = (mReg >> 8) & 7;
    hit = (ackValid && int'(ackLevel) == lvl && lvl != 0 && mPend != 0) ? 1 : 0;
    mVV = hit;
    mVD = hit ? (mReg & 8'hFF) : 0;
    mErr = (regSel && !regSupv) ? 1 : 0;
    nPend = mPend;
    if (regSel && regWr && regSupv && ((regWdata >> 8) & 7) == 0) nPend = 0;
    else if (tick && lvl != 0) nPend = 1;
    else if (hit) nPend = 0;
    mPend = nPend;
    if (regSel && regWr && regSupv) mReg = int'(regWdata) & 16'h07FF;
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle();
    regSel = 0; regWr = 0; regSupv = 0; tick = 0; ackValid = 0; ackLevel = 0; regWdata = 0;
  endtask

  task automatic wr(logic [15:0] d, logic supv);
    idle(); regSel = 1; regWr = 1; regSupv = supv; regWdata = d; step(); idle();
  endtask

  task automatic rdCheck(string tag, logic supv, int exp);
    idle(); regSel = 1; regSupv = supv; #1;
    chk(tag, int'(regRdata), exp);
    step(); idle();
  endtask

  initial begin
    mReg = 16'h000F; mPend = 0; mVV = 0; mVD = 0; mErr = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compareAll();
    rdCheck("R2 reset value", 1, 16'h000F);

    wr(16'hFFFF, 1);
    rdCheck("R1 reserved bits", 1, 16'h07FF);

    wr(16'h0042, 1);
    tick = 1; step(); idle(); step();
    chk("R5 tick disabled", int'(irqLevel), 0);

    wr(16'h035A, 1);
    rdCheck("R3 fields", 1, 16'h035A);
    tick = 1; step(); idle();
    chk("R4 level shown", int'(irqLevel), 3);
    ackValid = 1; ackLevel = 2; step(); idle();
    chk("R7 wrong level", int'(vecValid), 0);
    chk("R7 still pending", int'(irqLevel), 3);
    ackValid = 1; ackLevel = 3; step(); idle();
    chk("R6 strobe", int'(vecValid), 1);
    chk("R6 vector", int'(vecData), 16'h5A);
    chk("R6 cleared", int'(irqLevel), 0);
    step();
    chk("R6 single pulse", int'(vecValid), 0);
    ackValid = 1; ackLevel = 3; step(); idle();
    chk("R7 no pending", int'(vecValid), 0);

    tick = 1; step(); idle();
    wr(16'h005A, 1);
    chk("R9 disable clears", int'(irqLevel), 0);

    wr(16'h05C3, 1);
    tick = 1; step(); idle();
    tick = 1; ackValid = 1; ackLevel = 5; step(); idle();
    chk("R10 served", int'(vecValid), 1);
    chk("R10 still pending", int'(irqLevel), 5);
    ackValid = 1; ackLevel = 5; step(); idle();
    chk("R10 second vector", int'(vecData), 16'hC3);

    rdCheck("R8 user read", 0, 0);
    chk("R8 error pulse", int'(accessErr), 1);
    wr(16'h0711, 0);
    step();
    chk("R8 error one cycle", int'(accessErr), 0);
    rdCheck("R8 unchanged", 1, 16'h05C3);

    for (int i = 0; i < 40; i++) begin
      tick = (i % 3 == 0);
      ackValid = (i % 2 == 1);
      ackLevel = 3'(i % 8);
      if (i == 20) begin regSel = 1; regWr = 1; regSupv = 1; regWdata = 16'h0299; end
      step(); idle();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule